// File: doc/BRIEF.md
# Interrupt Polling and Blocking Controller

This block sits beside the instruction sequencer of an 8051-style CPU core. It decides when one pending, enabled interrupt request may start a vector cycle into its service routine. Requests are evaluated once per polling cycle of four states. Each source has its own enable bit, and one global enable bit gates every source. Each source also takes a priority level from two priority registers. The block keeps one in-service bit per level. Vectoring is refused while any of three blocking rules holds:
- a request of equal or higher level is already being serviced;
- the current state is not the last state of the instruction in progress;
- a return-from-interrupt or a write to the enable or priority registers has not yet been followed by one more complete instruction.

The low-numbered sources are external pins. They are active low and edge triggered, and each has a synchronizing sample stage and a pending flag. A pin's flag clears automatically when that source is vectored. The remaining sources are level requests driven by on-chip peripherals. The core supplies three status strobes: instruction-final-state, return-from-interrupt and register-write. The block answers with a one-state vector request that carries the source index and its level.

Top module: `irq_poll_ctrl`

## Requirements
- R1: After reset, vec_req_o, insvc_o and pend_o are all zero, and every enable and priority bit is zero.
- R2: A vector decision is taken only in the poll state, which is every fourth state counted from reset (states 3, 7, 11 and so on). A granted decision shows as a vec_req_o pulse of exactly one state, in the state that follows the poll state.
- R3: Source i can vector only when enable bit i and the global enable bit are both set. In the enable write data, bit i is source i and bit N_SRC is the global enable. A disabled source that is pending stays visible on pend_o[i] and produces no vector.
- R4: The level of source i is {high-priority bit i, low-priority bit i}. Level 3 is the most urgent. The eligible source with the highest level wins, and among sources at the same level the lowest index wins.
- R5: No vector is issued while insvc_o has a bit set at the candidate's level or at any higher level.
- R6: Issuing a vector sets insvc_o[level]. Each reti_i strobe clears the highest set bit of insvc_o.
- R7: No vector is issued unless instr_last_i is high in the poll state.
- R8: A reti_i or register-write strobe sets a hold. The hold clears at the first state where instr_last_i is high and no strobe is present. No vector is issued while the hold is set or while a strobe is present.
- R9: For source i < N_EXT, req_i[i] is an active-low pin. A high sample followed by a low sample on the next state sets pend_o[i]. The flag clears when that source is vectored. A pin held low does not set the flag again. For i >= N_EXT, pend_o[i] follows req_i[i] directly.
- R10: While vec_req_o is high, vec_src_o carries the winning source index and vec_lvl_o carries its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Request lines; the low N_EXT lines are active-low pins |
| instr_last_i | input | 1 | Current state is the last state of the instruction in progress |
| reti_i | input | 1 | Return-from-interrupt strobe |
| wr_en_i | input | 1 | Load the enable register from wr_data_i |
| wr_phi_i | input | 1 | Load the high-priority register from wr_data_i[N_SRC-1:0] |
| wr_plo_i | input | 1 | Load the low-priority register from wr_data_i[N_SRC-1:0] |
| wr_data_i | input | N_SRC+1 | Register write data |
| vec_req_o | output | 1 | One-state vector request |
| vec_src_o | output | SRC_W | Source index of the vector |
| vec_lvl_o | output | 2 | Level of the vector |
| insvc_o | output | 4 | In-service bit per level |
| pend_o | output | N_SRC | Pending flag per source |

## Verification
A corrupted in-service stack shows up at the ports in one of two ways. A same-level or lower-level request that should be held back vectors at the next poll state, at most four states later. Otherwise a return leaves the wrong insvc_o bits standing, and that is visible one state after the strobe. A stuck hold or a misaligned poll counter shows as a vector that is missing or shifted when the bench drives instr_last_i in chosen states, and this appears in the single state after the poll state. A pending flag that fails to clear shows on pend_o in the same state as the vector, and as a repeated vector after the next return.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
    localparam int NUM_LVL = 4;

    typedef logic [1:0] lvl_t;

    // True when a level at or above lvl is marked in service.
    function automatic logic lvl_blocked(input logic [NUM_LVL-1:0] insvc, input lvl_t lvl);
        logic b;
        b = 1'b0;
        for (int j = 0; j < NUM_LVL; j++) begin
            if (j >= int'(lvl) && insvc[j]) b = 1'b1;
        end
        return b;
    endfunction

    // Drop the most urgent in-service level.
    function automatic logic [NUM_LVL-1:0] clr_top(input logic [NUM_LVL-1:0] v);
        logic [NUM_LVL-1:0] r;
        logic done;
        r    = v;
        done = 1'b0;
        for (int j = NUM_LVL - 1; j >= 0; j--) begin
            if (!done && r[j]) begin
                r[j] = 1'b0;
                done = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] pin_i,
    input  logic [N_EXT-1:0] clr_i,
    output logic [N_EXT-1:0] flag_o
);
    typedef struct packed {
        logic [N_EXT-1:0] samp;
        logic [N_EXT-1:0] prev;
        logic [N_EXT-1:0] flag;
    } es_t;

    es_t es_d, es_q;

    always_comb begin
        es_d      = es_q;
        es_d.samp = pin_i;
        es_d.prev = es_q.samp;
        // a new falling edge wins over a same-state clear
        es_d.flag = (es_q.flag & ~clr_i) | (es_q.prev & ~es_q.samp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            es_q.samp <= '1;
            es_q.prev <= '1;
            es_q.flag <= '0;
        end else begin
            es_q <= es_d;
        end
    end

    assign flag_o = es_q.flag;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_SRC = 8,
    parameter int SRC_W = 3
) (
    input  logic [N_SRC-1:0]        elig_i,
    input  logic [N_SRC-1:0]        phi_i,
    input  logic [N_SRC-1:0]        plo_i,
    output logic                    found_o,
    output logic [SRC_W-1:0]        idx_o,
    output irq_poll_pkg::lvl_t      lvl_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        // walking downward with >= leaves the lowest index on a tie
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig_i[i] && (!found_o || {phi_i[i], plo_i[i]} >= lvl_o)) begin
                found_o = 1'b1;
                idx_o   = SRC_W'(i);
                lvl_o   = {phi_i[i], plo_i[i]};
            end
        end
    end
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl #(
    parameter int N_SRC       = 8,
    parameter int N_EXT       = 2,
    parameter int POLL_STATES = 4,
    parameter int SRC_W       = $clog2(N_SRC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC-1:0]           req_i,
    input  logic                       instr_last_i,
    input  logic                       reti_i,
    input  logic                       wr_en_i,
    input  logic                       wr_phi_i,
    input  logic                       wr_plo_i,
    input  logic [N_SRC:0]             wr_data_i,
    output logic                       vec_req_o,
    output logic [SRC_W-1:0]           vec_src_o,
    output logic [1:0]                 vec_lvl_o,
    output logic [3:0]                 insvc_o,
    output logic [N_SRC-1:0]           pend_o
);
    import irq_poll_pkg::*;

    localparam int PC_W = (POLL_STATES > 1) ? $clog2(POLL_STATES) : 1;
    localparam int EN_W = N_SRC + 1;

    typedef struct packed {
        logic [PC_W-1:0]    poll;
        logic               hold;
        logic [EN_W-1:0]    en;
        logic [N_SRC-1:0]   phi;
        logic [N_SRC-1:0]   plo;
        logic [NUM_LVL-1:0] insvc;
        logic               vreq;
        logic [SRC_W-1:0]   vsrc;
        lvl_t               vlvl;
    } st_t;

    st_t st_d, st_q;

    logic [N_EXT-1:0] ext_flag;
    logic [N_EXT-1:0] ext_clr;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] elig;
    logic             found;
    logic [SRC_W-1:0] pick_idx;
    lvl_t             pick_lvl;
    logic             tick;
    logic             strobe;
    logic             go;

    irq_edge_sync #(.N_EXT(N_EXT)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (req_i[N_EXT-1:0]),
        .clr_i  (ext_clr),
        .flag_o (ext_flag)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g < N_EXT) begin : g_ext
            assign pend[g]    = ext_flag[g];
            assign ext_clr[g] = go && (pick_idx == SRC_W'(g));
        end else begin : g_lvl
            assign pend[g] = req_i[g];
        end
    end

    assign elig = pend & st_q.en[N_SRC-1:0] & {N_SRC{st_q.en[N_SRC]}};

    irq_prio_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W)) pick_i (
        .elig_i  (elig),
        .phi_i   (st_q.phi),
        .plo_i   (st_q.plo),
        .found_o (found),
        .idx_o   (pick_idx),
        .lvl_o   (pick_lvl)
    );

    assign tick   = (st_q.poll == PC_W'(POLL_STATES - 1));
    assign strobe = reti_i | wr_en_i | wr_phi_i | wr_plo_i;
    assign go     = tick & instr_last_i & ~st_q.hold & ~strobe & found
                  & ~lvl_blocked(st_q.insvc, pick_lvl);

    always_comb begin
        st_d      = st_q;
        st_d.vreq = 1'b0;
        st_d.poll = tick ? '0 : st_q.poll + 1'b1;

        if (wr_en_i)  st_d.en  = wr_data_i;
        if (wr_phi_i) st_d.phi = wr_data_i[N_SRC-1:0];
        if (wr_plo_i) st_d.plo = wr_data_i[N_SRC-1:0];

        if (strobe)            st_d.hold = 1'b1;
        else if (instr_last_i) st_d.hold = 1'b0;

        if (reti_i) st_d.insvc = clr_top(st_q.insvc);

        if (go) begin
            st_d.vreq            = 1'b1;
            st_d.vsrc            = pick_idx;
            st_d.vlvl            = pick_lvl;
            st_d.insvc[pick_lvl] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_req_o = st_q.vreq;
    assign vec_src_o = st_q.vsrc;
    assign vec_lvl_o = st_q.vlvl;
    assign insvc_o   = st_q.insvc;
    assign pend_o    = pend;
endmodule

// File: rtl/irq_poll_ctrl_chk.sv
module irq_poll_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       strobe,
    input logic       instr_last_i,
    input logic       reti_i,
    input logic       vec_req_o,
    input logic [1:0] vec_lvl_o,
    input logic [3:0] insvc_o
);
    // R2: a vector follows a poll state
    a_r2_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_o |-> $past(tick));

    // R2: one-state pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_o |=> !vec_req_o);

    // R7: only at the last state of an instruction
    a_r7_final_state: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_o |-> $past(instr_last_i));

    // R8: never in a strobe state
    a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_o |-> !$past(strobe));

    // R6: the vectored level is marked
    a_r6_level_marked: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_o |-> insvc_o[vec_lvl_o]);

    // R5: nothing equal or higher was in service
    a_r5_no_preempt_block: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_o |-> (($past(insvc_o) >> vec_lvl_o) == 4'd0));

    // R6: a return drops exactly one level
    a_r6_reti_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && insvc_o != 4'd0) |=> ($countones(insvc_o) + 1 == $countones($past(insvc_o))));
endmodule

bind irq_poll_ctrl irq_poll_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .strobe       (strobe),
    .instr_last_i (instr_last_i),
    .reti_i       (reti_i),
    .vec_req_o    (vec_req_o),
    .vec_lvl_o    (vec_lvl_o),
    .insvc_o      (insvc_o)
);

// File: tb/irq_poll_ctrl_tb_top.sv
module irq_poll_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC = 8;
    localparam int SRC_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] req_i = 8'b0000_0011;
    logic             instr_last_i = 1'b1;
    logic             reti_i = 1'b0;
    logic             wr_en_i = 1'b0, wr_phi_i = 1'b0, wr_plo_i = 1'b0;
    logic [N_SRC:0]   wr_data_i = '0;
    logic             vec_req_o;
    logic [SRC_W-1:0] vec_src_o;
    logic [1:0]       vec_lvl_o;
    logic [3:0]       insvc_o;
    logic [N_SRC-1:0] pend_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    irq_poll_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .instr_last_i(instr_last_i),
        .reti_i(reti_i), .wr_en_i(wr_en_i), .wr_phi_i(wr_phi_i), .wr_plo_i(wr_plo_i),
        .wr_data_i(wr_data_i), .vec_req_o(vec_req_o), .vec_src_o(vec_src_o),
        .vec_lvl_o(vec_lvl_o), .insvc_o(insvc_o), .pend_o(pend_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // states since reset; equals the poll phase
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    task automatic wait_vec(input int maxc, output bit got, output int src, output int lvl);
        got = 0; src = -1; lvl = -1;
        for (int k = 0; k < maxc && !got; k++) begin
            @(negedge clk);
            if (vec_req_o) begin
                got = 1; src = int'(vec_src_o); lvl = int'(vec_lvl_o);
            end
        end
    endtask

    // kind 0: enable, 1: high priority, 2: low priority
    task automatic wr(input int kind, input logic [N_SRC:0] data);
        @(negedge clk);
        wr_data_i = data;
        wr_en_i = (kind == 0); wr_phi_i = (kind == 1); wr_plo_i = (kind == 2);
        @(negedge clk);
        wr_en_i = 0; wr_phi_i = 0; wr_plo_i = 0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti_i = 1;
        @(negedge clk); reti_i = 0;
    endtask

    task automatic at_phase(input int ph);
        do @(negedge clk); while (cyc % 4 != ph);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 vec_req", 32'(vec_req_o), 0);
        chk("R1 insvc", 32'(insvc_o), 0);
        chk("R1 pend", 32'(pend_o), 0);
    endtask

    task automatic t_enable();
        bit g; int s, l;
        req_i[3] = 1;
        wait_vec(12, g, s, l);
        chk("R1 R3 no vec with reset enables", 32'(g), 0);
        chk("R3 pending kept while disabled", 32'(pend_o[3]), 1);
        wr(0, 9'h008);
        wait_vec(12, g, s, l);
        chk("R3 no vec without global enable", 32'(g), 0);
        wr(0, 9'h108);
        wait_vec(12, g, s, l);
        chk("R3 vec when enabled", 32'(g), 1);
        chk("R10 src", 32'(s), 3);
        chk("R10 lvl", 32'(l), 0);
        @(negedge clk);
        chk("R2 pulse one state", 32'(vec_req_o), 0);
        chk("R6 insvc set level0", 32'(insvc_o), 4'b0001);
    endtask

    task automatic t_insvc();
        bit g; int s, l;
        req_i[2] = 1;
        wr(0, 9'h12C);
        wait_vec(12, g, s, l);
        chk("R5 equal level blocked", 32'(g), 0);
        req_i[3] = 0;
        wr(1, 9'h020);
        req_i[5] = 1;
        wait_vec(12, g, s, l);
        chk("R5 higher level preempts", 32'(g), 1);
        chk("R4 src5", 32'(s), 5);
        chk("R4 lvl2", 32'(l), 2);
        @(negedge clk);
        chk("R6 insvc 0101", 32'(insvc_o), 4'b0101);
        req_i[5] = 0;
        pulse_reti();
        chk("R6 reti pops level2", 32'(insvc_o), 4'b0001);
        wait_vec(10, g, s, l);
        chk("R5 still blocked by level0", 32'(g), 0);
        pulse_reti();
        chk("R6 reti pops level0", 32'(insvc_o), 4'b0000);
        wait_vec(12, g, s, l);
        chk("R5 src2 after return", 32'(s), 2);
        req_i[2] = 0;
        pulse_reti();
        chk("R6 empty", 32'(insvc_o), 0);
    endtask

    task automatic t_tie();
        bit g; int s, l;
        wr(1, 9'h000);
        wr(2, 9'h050);
        wr(0, 9'h1D0);
        @(negedge clk); req_i[4] = 1; req_i[6] = 1;
        wait_vec(12, g, s, l);
        chk("R4 tie lowest index", 32'(s), 4);
        chk("R4 tie lvl1", 32'(l), 1);
        req_i[4] = 0; req_i[6] = 0;
        pulse_reti();
        chk("R6 empty after tie", 32'(insvc_o), 0);
        wr(1, 9'h080);
        wr(2, 9'h0D0);
        @(negedge clk); req_i[4] = 1; req_i[7] = 1;
        wait_vec(12, g, s, l);
        chk("R4 higher level beats lower index", 32'(s), 7);
        chk("R10 lvl3", 32'(l), 3);
        req_i[4] = 0; req_i[7] = 0;
        pulse_reti();
    endtask

    task automatic t_edge();
        bit g; int s, l;
        wr(0, 9'h101);
        @(negedge clk); req_i[0] = 0;
        wait_vec(12, g, s, l);
        chk("R9 falling edge vectors", 32'(g), 1);
        chk("R9 src0", 32'(s), 0);
        chk("R9 flag cleared on vector", 32'(pend_o[0]), 0);
        pulse_reti();
        wait_vec(12, g, s, l);
        chk("R9 held low no retrigger", 32'(g), 0);
        chk("R9 flag stays clear", 32'(pend_o[0]), 0);
        req_i[0] = 1;
        @(negedge clk); req_i[1] = 0;
        @(negedge clk); @(negedge clk); req_i[1] = 1;
        wait_vec(8, g, s, l);
        chk("R3 disabled pin no vec", 32'(g), 0);
        chk("R9 disabled pin flag set", 32'(pend_o[1]), 1);
    endtask

    task automatic t_final_hold();
        bit g; int s, l;
        @(negedge clk); instr_last_i = 0; req_i[3] = 1;
        wr(0, 9'h108);
        wait_vec(16, g, s, l);
        chk("R7 no vec without final state", 32'(g), 0);
        at_phase(3); instr_last_i = 1;
        @(negedge clk); instr_last_i = 0;
        chk("R8 hold blocks first final state", 32'(vec_req_o), 0);
        at_phase(1); instr_last_i = 1;
        @(negedge clk); instr_last_i = 0;
        chk("R2 no decision off poll state", 32'(vec_req_o), 0);
        at_phase(3); instr_last_i = 1;
        @(negedge clk); instr_last_i = 0;
        chk("R2 vec right after poll state", 32'(vec_req_o), 1);
        chk("R10 src3", 32'(vec_src_o), 3);
        req_i[3] = 0;
        pulse_reti();
        @(negedge clk); instr_last_i = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_enable();
        t_insvc();
        t_tie();
        t_edge();
        t_final_hold();
        report();
        $finish;
    end
endmodule